// File: doc/BRIEF.md
# CAN Receive Bit Sampler

This block turns the oversampled receive line of a CAN node into a stream of sampled bits. While idle it watches the line. The first clock in which it sees the dominant (low) level is taken as the start of a frame and as the first timing reference. From then on it takes one sample per nominal bit period, a programmable number of clocks after the start of each bit. Each sample is presented as a one-clock strobe together with the sampled level and a raw bit index. The index counts every bit on the wire, stuff bits included. Destuffing and field decoding are left to the logic downstream.

Timing follows the bus. Every recessive-to-dominant transition seen while receiving becomes the new reference. The next sample is then placed at that edge plus the sample-point offset, plus whole bit periods for each bit still to come. The bit period and the sample offset are integer clock counts. They are captured while the block is idle and held for the whole frame. A frame-done input from the parser returns the block to idle.

The output stream has a valid strobe and no ready: a bus line cannot be stalled, so the consumer must accept every strobe in the clock it appears. The inputs are `rx_i`, the configuration and `frame_done_i`. All three are sampled on the rising clock edge.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset, `bit_valid_o` is 0, `bit_value_o` is 1, `bit_index_o` is 0 and the block is idle.
- R2: While idle and the line stays high, no strobe is produced. The first clock in which the synchronized line reads low starts a frame and becomes the timing reference.
- R3: If the dominant start level reaches `rx_i` in clock cycle c, the strobe for bit 0 appears in cycle c + SYNC_STAGES + 1 + spt, where spt is the sample offset. It carries index 0 and value 0. With the default SYNC_STAGES = 2 this is cycle c + 3 + spt.
- R4: While no falling edge arrives, consecutive strobes are exactly bit_clks cycles apart. The index grows by one per strobe. The value is the line level at that sample clock.
- R5: A falling edge that reaches `rx_i` in cycle e, when no sample falls in the clock where it is seen, becomes the new reference. The next strobe appears in cycle e + SYNC_STAGES + 1 + spt, and the index carries on from the value it had.
- R6: When a falling edge is seen in the same clock as a sample, the sample is still taken, with value 0. The next strobe follows bit_clks + spt cycles later.
- R7: `bit_valid_o` is high for exactly one clock per sampled bit. This requires bit_clks >= 2 and 1 <= spt < bit_clks.
- R8: The bit period and the sample offset are captured in every idle clock, including the start clock. Changes to them while receiving have no effect on the timing of the current frame.
- R9: `frame_done_i` high while receiving returns the block to idle one clock later and clears `bit_index_o` to 0. It also suppresses a sample that falls in the same clock. While idle, `frame_done_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the line |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Receive line, 0 = dominant, 1 = recessive |
| cfg_bit_clks_i | input | CW | Nominal bit period in clocks |
| cfg_spt_clks_i | input | CW | Sample point, clocks after the start of a bit |
| frame_done_i | input | 1 | End of frame from the parser; returns the block to idle |
| bit_valid_o | output | 1 | One-clock strobe per sampled bit |
| bit_value_o | output | 1 | Sampled line level |
| bit_index_o | output | IW | Raw bit index of the sample, stuff bits included |

## Verification
Two events can land in the same clock: a resynchronizing falling edge and a scheduled sample. The bench provokes this by placing a falling edge exactly at the nominal sample point of bit 2. It then judges the case by three things: bit 2 must still be reported as 0, no extra strobe may follow at only the offset distance, and bit 3 must arrive bit_clks + spt clocks after the edge. A second collision, between a sample and `frame_done_i`, is provoked in the same way and must yield no strobe and a cleared index.

// File: rtl/can_bs_pkg.sv
package can_bs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bs_state_e;
endpackage

// File: rtl/can_bs_sync.sv
module can_bs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= rx_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], rx_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= pipe_q[STAGES-1];
  end

  assign level_o = pipe_q[STAGES-1];
  assign fall_o  = last_q & ~level_o;

  // R5
  fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/can_bs_cfg.sv
module can_bs_cfg #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] bit_i,
  input  logic [CW-1:0] spt_i,
  output logic [CW-1:0] bit_o,
  output logic [CW-1:0] spt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_o <= '0;
      spt_o <= '0;
    end else if (load_i) begin
      bit_o <= bit_i;
      spt_o <= spt_i;
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(bit_o) && $stable(spt_o)));
endmodule

// File: rtl/can_bs_timer.sv
module can_bs_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          fall_i,
  input  logic [CW-1:0] spt_now_i,
  input  logic [CW-1:0] bit_q_i,
  input  logic [CW-1:0] spt_q_i,
  output logic          hit_o
);
  localparam int RW = CW + 1;

  logic [RW-1:0] remain_q;
  logic [RW-1:0] one_x;
  logic [RW-1:0] bit_x;
  logic [RW-1:0] spt_x;

  assign one_x = RW'(1);
  assign bit_x = {1'b0, bit_q_i};
  assign spt_x = {1'b0, spt_q_i};
  assign hit_o = run_i && (remain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (start_i) begin
      remain_q <= {1'b0, spt_now_i} - one_x;
    end else if (run_i) begin
      unique case ({fall_i, hit_o})
        2'b11:   remain_q <= bit_x + spt_x - one_x;
        2'b10:   remain_q <= spt_x - one_x;
        2'b01:   remain_q <= bit_x - one_x;
        default: remain_q <= remain_q - one_x;
      endcase
    end
  end

  // R6
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && fall_i && hit_o) |=> !hit_o);
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
  import can_bs_pkg::*;
#(
  parameter int CW          = 12,
  parameter int IW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic [CW-1:0] cfg_bit_clks_i,
  input  logic [CW-1:0] cfg_spt_clks_i,
  input  logic          frame_done_i,
  output logic          bit_valid_o,
  output logic          bit_value_o,
  output logic [IW-1:0] bit_index_o
);
  bs_state_e     state_q;
  logic          level;
  logic          fall;
  logic          hit;
  logic          start;
  logic          is_idle;
  logic          is_run;
  logic [CW-1:0] bit_q;
  logic [CW-1:0] spt_q;
  logic [IW-1:0] idx_q;

  assign is_idle = (state_q == ST_IDLE);
  assign is_run  = (state_q == ST_RUN);
  assign start   = is_idle && !level;

  can_bs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_i    (rx_i),
    .level_o (level),
    .fall_o  (fall)
  );

  can_bs_cfg #(.CW(CW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (is_idle),
    .bit_i  (cfg_bit_clks_i),
    .spt_i  (cfg_spt_clks_i),
    .bit_o  (bit_q),
    .spt_o  (spt_q)
  );

  can_bs_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .run_i     (is_run),
    .fall_i    (fall),
    .spt_now_i (cfg_spt_clks_i),
    .bit_q_i   (bit_q),
    .spt_q_i   (spt_q),
    .hit_o     (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      bit_valid_o <= 1'b0;
      bit_value_o <= 1'b1;
      bit_index_o <= '0;
    end else begin
      bit_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (!level) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (frame_done_i) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            bit_index_o <= '0;
          end else if (hit) begin
            bit_valid_o <= 1'b1;
            bit_value_o <= level;
            bit_index_o <= idx_q;
            idx_q       <= idx_q + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |=> !bit_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |=> !bit_valid_o);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_run && frame_done_i) |=> (is_idle && !bit_valid_o && bit_index_o == '0));
endmodule

// File: tb/can_bit_sampler_tb.sv
module can_bit_sampler_tb;
  localparam int CW = 12;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_i = 1'b1;
  logic [CW-1:0] cfg_bit = 12'd10;
  logic [CW-1:0] cfg_spt = 12'd7;
  logic          frame_done_i = 1'b0;
  logic          bit_valid_o;
  logic          bit_value_o;
  logic [IW-1:0] bit_index_o;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int nv = 0;
  int c0 = 0;
  int vcyc [0:63];
  int vval [0:63];
  int vidx [0:63];
  bit done_flag = 1'b0;

  can_bit_sampler #(.CW(CW), .IW(IW), .SYNC_STAGES(2)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_i           (rx_i),
    .cfg_bit_clks_i (cfg_bit),
    .cfg_spt_clks_i (cfg_spt),
    .frame_done_i   (frame_done_i),
    .bit_valid_o    (bit_valid_o),
    .bit_value_o    (bit_value_o),
    .bit_index_o    (bit_index_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (bit_valid_o && nv < 64) begin
      vcyc[nv] = cyc;
      vval[nv] = int'(bit_value_o);
      vidx[nv] = int'(bit_index_o);
      nv = nv + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input int k, input int ecyc, input int eval, input int eidx);
    chk(req, $sformatf("bit %0d cycle", k), vcyc[k], ecyc);
    chk(req, $sformatf("bit %0d value", k), vval[k], eval);
    chk(req, $sformatf("bit %0d index", k), vidx[k], eidx);
  endtask

  task automatic put(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_i = v;
    end
  endtask

  task automatic start_frame(input int n);
    @(posedge clk); #1;
    rx_i = 1'b0;
    c0 = cyc;
    nv = 0;
    put(1'b0, n - 1);
  endtask

  task automatic end_frame();
    @(posedge clk); #1;
    frame_done_i = 1'b1;
    @(posedge clk); #1;
    frame_done_i = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "valid in reset", int'(bit_valid_o), 0);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "valid", int'(bit_valid_o), 0);
    chk("R1", "value", int'(bit_value_o), 1);
    chk("R1", "index", int'(bit_index_o), 0);
  endtask

  task automatic t_idle();
    nv = 0;
    put(1'b1, 20);
    @(posedge clk); #1 frame_done_i = 1'b1;
    @(posedge clk); #1 frame_done_i = 1'b0;
    put(1'b1, 20);
    chk("R2", "strobes while idle", nv, 0);
    chk("R9", "index after idle done", int'(bit_index_o), 0);
  endtask

  task automatic t_basic();
    logic [7:0] pat = 8'b0111_0010;
    start_frame(10);
    for (int i = 1; i < 8; i++) put(pat[i], 10);
    put(1'b1, 3);
    end_frame();
    chk("R7", "strobe count", nv, 8);
    chk_bit("R3", 0, c0 + 10, 0, 0);
    for (int k = 1; k < 8; k++) chk_bit("R4", k, c0 + 10 + 10 * k, int'(pat[k]), k);
  endtask

  task automatic t_resync_late();
    start_frame(10);
    put(1'b1, 23);
    put(1'b0, 10);
    put(1'b1, 3);
    end_frame();
    chk("R5", "late strobe count", nv, 4);
    chk_bit("R4", 1, c0 + 20, 1, 1);
    chk_bit("R4", 2, c0 + 30, 1, 2);
    chk_bit("R5", 3, c0 + 43, 0, 3);
  endtask

  task automatic t_resync_early();
    start_frame(10);
    put(1'b1, 16);
    put(1'b0, 10);
    put(1'b1, 3);
    end_frame();
    chk("R5", "early strobe count", nv, 3);
    chk_bit("R5", 1, c0 + 20, 1, 1);
    chk_bit("R5", 2, c0 + 36, 0, 2);
  endtask

  task automatic t_coincide();
    start_frame(10);
    put(1'b1, 17);
    put(1'b0, 10);
    put(1'b1, 11);
    end_frame();
    chk("R6", "coincide strobe count", nv, 4);
    chk_bit("R6", 2, c0 + 30, 0, 2);
    chk_bit("R6", 3, c0 + 47, 1, 3);
  endtask

  task automatic t_cfg();
    logic [5:0] pat = 6'b10_1100;
    cfg_bit = 12'd8;
    cfg_spt = 12'd3;
    start_frame(8);
    cfg_bit = 12'd20;
    cfg_spt = 12'd15;
    for (int i = 1; i < 6; i++) put(pat[i], 8);
    put(1'b1, 3);
    end_frame();
    cfg_bit = 12'd10;
    cfg_spt = 12'd7;
    chk("R8", "strobe count", nv, 6);
    chk_bit("R3", 0, c0 + 6, 0, 0);
    for (int k = 1; k < 6; k++) chk_bit("R8", k, c0 + 6 + 8 * k, int'(pat[k]), k);
  endtask

  task automatic t_done();
    start_frame(10);
    put(1'b1, 10);
    put(1'b1, 10);
    put(1'b1, 9);
    end_frame();
    chk("R9", "strobes before done", nv, 3);
    chk("R9", "index cleared", int'(bit_index_o), 0);
    chk("R9", "valid low", int'(bit_valid_o), 0);
    start_frame(10);
    put(1'b1, 3);
    end_frame();
    chk("R9", "restart strobes", nv, 1);
    chk_bit("R9", 0, c0 + 10, 0, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_idle();
    t_basic();
    t_resync_late();
    t_resync_early();
    t_coincide();
    t_cfg();
    t_done();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule